// File: doc/BRIEF.md
# Programmable Divider Output Timer

This block is an 8-bit timer that produces a square wave by repeated division. A free-running divider supplies a set of power-of-two prescaler taps; one tap, chosen in the control register, paces an 8-bit up-counter. Each time the counter reaches the value held in the period register, the counter restarts from zero and an output flip-flop inverts. The flip-flop drives the single output pin, so the pin frequency is the tap rate divided by twice the period value.

Software reaches the block through a small write port. A select line picks the control register or the period register. The control register holds four fields: the pin level, the tap select, the run bit and the mode. The pin level can be preset only while the timer is stopped. Stopping the timer freezes the pin. The period register has no shadow copy, so the compare logic uses a new value from the cycle after the write.

Top module: `pdo_timer`

## Requirements
- R1: A synchronous reset clears the counter and the control register, which stops the timer. It also sets the period register to 0xFF and drives `pdo_out` low. After reset, a start with the fastest tap produces the first pin edge 255 cycles after the start write.
- R2: The control byte is laid out as follows. Bit 7 is the pin level. Bits 6:4 are the tap select. Bit 3 is run. Bits 2:0 are the mode. The counter advances only while run is 1 and the mode is 3'b001. Any other mode freezes both the counter and the pin.
- R3: Tap select codes 0 to 7 give one count pulse every 2^11, 2^7, 2^5, 2^3, 2^2, 2^1, 2^0 and 2^0 base clock cycles, in that order of codes.
- R4: A control write that changes run from 0 to 1 clears the counter. The first pin edge then follows `period` count pulses after the write. A control write that leaves run at 1 does not clear the counter.
- R5: On the count pulse where the incremented count equals the period, the counter returns to 0 and `pdo_out` inverts. The pin therefore has a half-period of `period` count pulses.
- R6: A period value of 0 acts as 256 count pulses.
- R7: A period write is used by the compare from the next cycle, even while the timer runs. If the new value is not above the current count, the counter runs on to 255, wraps to 0 and matches on its way up.
- R8: While run is 0, `pdo_out` keeps its level. A write that clears run leaves the pin unchanged.
- R9: A control write while run is 0 loads bit 7 into the pin flip-flop, and the pin shows it from the next cycle.
- R10: Bit 7 of a control write made while run is 1 is ignored. The pin then changes only at compare matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 period register |
| wr_data | input | 8 | Write data |
| pdo_out | output | 1 | Square-wave output pin |

## Verification
The only visible result is the pin, so an internal error shows up as a pin edge at the wrong time or a missing edge. A wrong count or a mis-handled period value moves the next edge, which becomes visible within one half-period, at most 256 count pulses later. A wrongly loaded or wrongly held level shows on the very next cycle. A wrong tap shows as a changed edge-to-edge interval, measured over two consecutive edges. Because the bench checks the pin every cycle against its own model, a divider or counter that drifts by a single cycle is caught at the first edge it moves.

// File: rtl/pdo_pkg.sv
package pdo_pkg;

  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int MODE_W   = 3;

  localparam int LVL_BIT  = 7;
  localparam int SEL_LSB  = 4;
  localparam int RUN_BIT  = 3;
  localparam int MODE_LSB = 0;

  localparam logic [MODE_W-1:0] MODE_DIV = 3'b001;

  // Power-of-two exponent of the base-clock division for each tap code.
  function automatic int tap_exp(input int code);
    case (code)
      0:       return 11;
      1:       return 7;
      2:       return 5;
      3:       return 3;
      4:       return 2;
      5:       return 1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/pdo_prescaler.sv
module pdo_prescaler #(
  parameter int DIV_W = 12,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP = 1 << SEL_W;

  logic [DIV_W-1:0] div_q;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // A tap fires when all bits below its exponent are ones.
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int E = pdo_pkg::tap_exp(g);
    localparam logic [DIV_W-1:0] MASK = {DIV_W{1'b1}} >> (DIV_W - E);
    assign tap_hit[g] = (div_q & MASK) == MASK;
  end

  assign tick = tap_hit[sel];

  // R3: the undivided taps pulse on every cycle
  assert_fast_tap_R3: assert property (@(posedge clk) disable iff (rst)
    (pdo_pkg::tap_exp(int'(sel)) == 0) |-> tick);

  // R3: a divided tap never pulses on two cycles in a row
  assert_tap_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tap_hit[1] |=> !tap_hit[1]);

endmodule

// File: rtl/pdo_regs.sv
module pdo_regs #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [DATA_W-1:0] period_q,
  output logic              start,
  output logic              lvl_load,
  output logic              lvl_data
);
  import pdo_pkg::*;

  logic ctrl_wr, per_wr;

  assign ctrl_wr  = wr_en && !wr_sel;
  assign per_wr   = wr_en && wr_sel;
  assign start    = ctrl_wr && wr_data[RUN_BIT] && !run_q;
  assign lvl_load = ctrl_wr && !run_q;
  assign lvl_data = wr_data[LVL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      mode_q <= '0;
    end else if (ctrl_wr) begin
      run_q  <= wr_data[RUN_BIT];
      sel_q  <= wr_data[SEL_LSB +: SEL_W];
      mode_q <= wr_data[MODE_LSB +: MODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         period_q <= '1;
    else if (per_wr) period_q <= wr_data;
  end

  // R7: a period write lands unbuffered in one cycle
  assert_period_direct_R7: assert property (@(posedge clk) disable iff (rst)
    per_wr |=> period_q == $past(wr_data));

  // R2: the run field follows its bit of the control byte
  assert_run_field_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> run_q == $past(wr_data[RUN_BIT]));

  // R4: a start comes only from a stopped timer
  assert_start_from_stop_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q && !$past(run_q));

endmodule

// File: rtl/pdo_core.sv
module pdo_core #(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic [MODE_W-1:0] mode,
  input  logic              start,
  input  logic              lvl_load,
  input  logic              lvl_data,
  input  logic [CNT_W-1:0]  period,
  output logic              pdo,
  output logic              match
);
  import pdo_pkg::*;

  // A zero period counts the full range of the counter.
  function automatic logic [CNT_W:0] span_of(input logic [CNT_W-1:0] p);
    return (p == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, p};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_step;
  logic             active;
  logic             step_en;

  assign active   = run && (mode == MODE_DIV);
  assign step_en  = active && tick;
  assign cnt_step = {1'b0, cnt_q} + 1'b1;
  assign match    = step_en && (cnt_step == span_of(period));

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (start)   cnt_q <= '0;
    else if (match)   cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_step[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           pdo <= 1'b0;
    else if (match)    pdo <= ~pdo;
    else if (lvl_load) pdo <= lvl_data;
  end

  // R5: a match inverts the pin
  assert_match_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    match |=> pdo != $past(pdo));

  // R5: a match restarts the count
  assert_match_clear_R5: assert property (@(posedge clk) disable iff (rst)
    match |=> cnt_q == '0);

  // R4: a start restarts the count
  assert_start_clear_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == '0);

  // R8: a stopped timer holds the pin unless a level is loaded
  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!run && !lvl_load) |=> $stable(pdo));

  // R10: a running timer moves the pin only on a match
  assert_run_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (run && !match) |=> $stable(pdo));

  // R2: a foreign mode freezes the count
  assert_mode_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    ((mode != MODE_DIV) && !start) |=> $stable(cnt_q));

  // R6: a zero period matches only from the top count
  assert_zero_span_R6: assert property (@(posedge clk) disable iff (rst)
    (match && (period == '0)) |-> (cnt_q == '1));

endmodule

// File: rtl/pdo_timer.sv
module pdo_timer #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pdo_out
);
  localparam int SEL_W  = pdo_pkg::SEL_W;
  localparam int MODE_W = pdo_pkg::MODE_W;
  localparam int CNT_W  = DATA_W;

  logic              run_q;
  logic [SEL_W-1:0]  sel_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  period_q;
  logic              start;
  logic              lvl_load;
  logic              lvl_data;
  logic              tick;
  logic              match;

  pdo_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W), .MODE_W(MODE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .run_q    (run_q),
    .sel_q    (sel_q),
    .mode_q   (mode_q),
    .period_q (period_q),
    .start    (start),
    .lvl_load (lvl_load),
    .lvl_data (lvl_data)
  );

  pdo_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (sel_q),
    .tick (tick)
  );

  pdo_core #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .run      (run_q),
    .mode     (mode_q),
    .start    (start),
    .lvl_load (lvl_load),
    .lvl_data (lvl_data),
    .period   (period_q),
    .pdo      (pdo_out),
    .match    (match)
  );

  // R1: reset drives the pin low
  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !pdo_out);

  // R5: the pin only moves on a match or a stopped-timer load
  assert_pin_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (!match && !lvl_load) |=> $stable(pdo_out));

endmodule

// File: tb/pdo_timer_tb.sv
`timescale 1ns/1ps
module pdo_timer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pdo_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  pdo_timer u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pdo_out (pdo_out)
  );

  // ---------------- bench model restated from the requirements ----------
  function automatic int b_div(input logic [2:0] code);
    int table_e[8] = '{11, 7, 5, 3, 2, 1, 0, 0};
    return 1 << table_e[code];
  endfunction

  function automatic bit b_pulse(input logic [11:0] d, input logic [2:0] code);
    return ((int'(d) + 1) % b_div(code)) == 0;
  endfunction

  function automatic int b_span(input logic [7:0] p);
    return (p == 8'd0) ? 256 : int'(p);
  endfunction

  logic [11:0] m_div;
  logic        m_run;
  logic [2:0]  m_sel;
  logic [2:0]  m_mode;
  logic [7:0]  m_per;
  int          m_cnt;
  logic        m_out;

  always @(posedge clk) begin
    if (rst) begin
      m_div <= '0; m_run <= 1'b0; m_sel <= '0; m_mode <= '0;
      m_per <= 8'hFF; m_cnt <= 0; m_out <= 1'b0;
    end else begin
      m_div <= m_div + 1'b1;
      if (wr_en && !wr_sel) begin
        m_run  <= wr_data[3];
        m_sel  <= wr_data[6:4];
        m_mode <= wr_data[2:0];
        if (!m_run) m_out <= wr_data[7];
      end
      if (wr_en && wr_sel) m_per <= wr_data;
      if (wr_en && !wr_sel && wr_data[3] && !m_run) m_cnt <= 0;
      else if (m_run && m_mode == 3'b001 && b_pulse(m_div, m_sel)) begin
        if (m_cnt + 1 == b_span(m_per)) begin
          m_cnt <= 0;
          m_out <= ~m_out;
        end else begin
          m_cnt <= (m_cnt + 1) % 256;
        end
      end
    end
  end

  // ---------------- checking helpers ------------------------------------
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_edge(output int cyc);
    logic v;
    v = pdo_out;
    cyc = 0;
    while (pdo_out == v && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) chk("R5 model pin", int'(pdo_out), int'(m_out));
  end

  initial begin
    #3000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  // ---------------- stimulus --------------------------------------------
  initial begin
    int cyc;
    logic lv;
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    chk("R1 reset pin", int'(pdo_out), 0);

    // R1: default period 0xFF, fastest tap, first edge 255 cycles on
    wr(1'b0, 8'h69);
    idle(254); chk("R1 default period, before edge", int'(pdo_out), 0);
    idle(1);   chk("R1 default period, at edge", int'(pdo_out), 1);

    // R8: stopping, even with bit 7 clear in the write, holds the level
    wr(1'b0, 8'h61);
    chk("R8 pin at stop", int'(pdo_out), 1);
    idle(300);
    chk("R8 pin held while stopped", int'(pdo_out), 1);

    // R9: level load while stopped
    wr(1'b0, 8'h61); chk("R9 load low", int'(pdo_out), 0);
    wr(1'b0, 8'hE1); chk("R9 load high", int'(pdo_out), 1);

    // R4 / R5 / R10: period 5, start with level 1
    wr(1'b1, 8'd5);
    wr(1'b0, 8'hE9);
    chk("R9 level loaded with start", int'(pdo_out), 1);
    idle(4); chk("R4 no edge before period", int'(pdo_out), 1);
    idle(1); chk("R5 first edge", int'(pdo_out), 0);
    idle(1);
    wr(1'b0, 8'hE9);
    chk("R10 bit7 ignored while running", int'(pdo_out), 0);
    idle(2); chk("R4 rewrite keeps count", int'(pdo_out), 0);
    idle(1); chk("R5 second edge", int'(pdo_out), 1);

    // R7: period changes while running
    wr(1'b1, 8'd2);
    chk("R7 before new edge", int'(pdo_out), 1);
    idle(1); chk("R7 new period used at once", int'(pdo_out), 0);
    idle(2); chk("R7 new half period", int'(pdo_out), 1);
    wr(1'b1, 8'd200);
    idle(5);
    wr(1'b1, 8'd3);
    idle(251); chk("R7 wrap before match", int'(pdo_out), 1);
    idle(1);   chk("R7 match after wrap", int'(pdo_out), 0);

    // R6: zero period means 256
    wr(1'b0, 8'h61);
    wr(1'b1, 8'd0);
    wr(1'b0, 8'h69);
    idle(255); chk("R6 no edge at 255", int'(pdo_out), 0);
    idle(1);   chk("R6 edge at 256", int'(pdo_out), 1);

    // R3: tap code 1 divides by 128, period 1
    wr(1'b0, 8'h11);
    wr(1'b1, 8'd1);
    wr(1'b0, 8'h19);
    wait_edge(cyc);
    wait_edge(cyc);
    chk("R3 tap 1 interval", cyc, 128);

    // R3: tap code 5 divides by 2, period 3
    wr(1'b0, 8'h51);
    wr(1'b1, 8'd3);
    wr(1'b0, 8'h59);
    wait_edge(cyc);
    wait_edge(cyc);
    chk("R3 tap 5 interval", cyc, 6);

    // R2: a foreign mode freezes the pin; restoring the mode resumes it
    wr(1'b0, 8'h61);
    wr(1'b1, 8'd2);
    wr(1'b0, 8'h69);
    idle(5);
    wr(1'b0, 8'h6A);
    lv = pdo_out;
    idle(50);
    chk("R2 foreign mode holds pin", int'(pdo_out), int'(lv));
    wr(1'b0, 8'h69);
    wait_edge(cyc);
    wait_edge(cyc);
    chk("R2 resumed interval", cyc, 2);

    // Constrained random phase against the bench model
    cmp_en = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if ($urandom_range(0, 15) == 0) begin
        wr_en = 1'b1;
        if ($urandom_range(0, 1) == 0) begin
          wr_sel = 1'b0;
          wr_data[7]   = 1'($urandom_range(0, 1));
          wr_data[6:4] = 3'($urandom_range(4, 7));
          wr_data[3]   = ($urandom_range(0, 3) != 0);
          wr_data[2:0] = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 7)) : 3'b001;
        end else begin
          wr_sel = 1'b1;
          wr_data = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                                : 8'($urandom_range(0, 8));
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    cmp_en = 1'b0;
    finish_run();
  end

endmodule